// File: doc/BRIEF.md
# Page Access Rights Checker

This block sits after a page-table walk and rules on a single memory access, using only the permission summary that the walk produced. Its inputs are the combined user, writable and no-execute bits and the leaf's protection-key field, dirty bit and reserved-bit verdict. It also takes the access kind, the privilege of the requester, and the paging control flags and key registers that shape the decision. From these it grants read, write and execute rights for caching in a translation buffer, raises a fault with an error code, or requests that the leaf's accessed and dirty bits be set.

All of the decision logic is combinational. A single register stage captures the result, so the answer for inputs presented at one rising edge appears after that edge. The requester qualifies each access with `valid_i`, and `valid_o` follows it one cycle later.

Top module: `acc_rights_chk`

## Requirements
- R1: The outputs are registered. Inputs sampled at a rising edge appear on the outputs after that edge and not before it, and `valid_o` follows `valid_i` with one cycle of latency. While `rst_ni` is low, every output is 0.
- R2: A user-mode access (`user_mode_i`=1) to a page whose combined user bit `pg_user_i` is 0 is a protection fault.
- R3: Write is permitted when `pg_write_i` is 1. It is also permitted for a supervisor access when `wp_i` is 0. Access kind encoding on `acc_type_i`: 00 is read, 01 is write, 10 is fetch, and 11 is treated as read.
- R4: When `sna_i` is 1 and the access is supervisor mode, a page with `pg_user_i`=1 gets neither read nor write permission.
- R5: Execute is permitted only when `pg_nx_i` is 0. In addition, one of the following must hold: the access is user mode, `xprot_i` is 0, or `pg_user_i` is 0.
- R6: Protection keys act only when `lma_i` is 1. A page with `pg_user_i`=1 uses `ukey_i`, but only when `ukey_en_i` is 1. A page with `pg_user_i`=0 uses `skey_i`, but only when `skey_en_i` is 1. In every other case keys restrict nothing.
- R7: For key value k (`pkey_i`), bit 2k of the selected key register removes read and write. Bit 2k+1 removes write, but only for a user access or when `wp_i` is 1. Keys never remove execute.
- R8: When the key rules alone deny the requested access, and no earlier fault applies, `err_code_o` bit 5 is set as well as bit 0.
- R9: On a fault, `err_code_o` has bit 0 set for protection and reserved-bit faults, bit 1 set for a write access, bit 2 set for a user-mode access, and bit 3 set when `rsvd_i` is 1. `rsvd_i`=1 always faults and never sets bit 5. Without a fault, `err_code_o` is 0.
- R10: `err_code_o` bit 4 is set on a faulting fetch only when `nxe_i` and `pae_i` are both 1, or when `xprot_i` is 1.
- R11: A permitted write with `pg_dirty_i`=0 raises `dirty_upd_o`. `grant_w_o` is 1 only when write is permitted and either the page is already dirty or the access is a write.
- R12: On a fault, all three grants are 0 and `dirty_upd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Access presented this cycle |
| acc_type_i | input | 2 | Access kind: 00 read, 01 write, 10 fetch |
| user_mode_i | input | 1 | Requester is in user mode |
| pg_user_i | input | 1 | Combined user bit of the walk |
| pg_write_i | input | 1 | Combined writable bit |
| pg_nx_i | input | 1 | Combined no-execute bit |
| pg_dirty_i | input | 1 | Leaf dirty bit |
| pkey_i | input | KEY_W | Leaf protection-key field |
| rsvd_i | input | 1 | Walk found a reserved-bit violation |
| wp_i | input | 1 | Supervisor write-protect enable |
| xprot_i | input | 1 | Supervisor execute protection for user pages |
| sna_i | input | 1 | Supervisor no-access to user pages active |
| nxe_i | input | 1 | No-execute enable |
| pae_i | input | 1 | Physical address extension enabled |
| lma_i | input | 1 | Long mode active |
| ukey_en_i | input | 1 | User key register enable |
| ukey_i | input | KREG_W | User key rights register |
| skey_en_i | input | 1 | Supervisor key register enable |
| skey_i | input | KREG_W | Supervisor key rights register |
| valid_o | output | 1 | Result valid |
| grant_r_o | output | 1 | Read may be cached |
| grant_w_o | output | 1 | Write may be cached |
| grant_x_o | output | 1 | Execute may be cached |
| fault_o | output | 1 | Access faults |
| err_code_o | output | 6 | Fault error code |
| dirty_upd_o | output | 1 | Set accessed and dirty bits in the leaf |

## Verification
The interesting overlap is a key denial and an ordinary permission denial landing on the same access. An example is a user write to a read-only page whose key also has its write-disable bit set. In that case the error code must carry both the key bit and the protection bit. A second overlap is a reserved-bit verdict arriving together with a key access-disable. There the reserved fault must win, and the key bit must stay clear. Directed vectors set up both pairings, and a long random run mixes them freely. Every output is compared against a reference function in the bench, which applies the requirements in their stated priority: reserved-bit fault first, then the user-bit fault, then the key check, then the plain rights check.

// File: rtl/acc_chk_pkg.sv
package acc_chk_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_FX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  localparam int ERR_W  = 6;
  localparam int EB_P   = 0;
  localparam int EB_W   = 1;
  localparam int EB_U   = 2;
  localparam int EB_RSV = 3;
  localparam int EB_ID  = 4;
  localparam int EB_PK  = 5;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } rwx_t;
endpackage

// File: rtl/acc_rights_base.sv
module acc_rights_base
  import acc_chk_pkg::*;
(
  input  logic user_mode_i,
  input  logic pg_user_i,
  input  logic pg_write_i,
  input  logic pg_nx_i,
  input  logic wp_i,
  input  logic xprot_i,
  input  logic sna_i,
  output rwx_t base_o,
  output logic user_flt_o
);
  logic rd_ok;

  // supervisor no-access mode hides user pages from loads and stores
  assign rd_ok      = !(sna_i && !user_mode_i && pg_user_i);
  assign base_o.r   = rd_ok;
  assign base_o.w   = rd_ok && (pg_write_i || (!user_mode_i && !wp_i));
  assign base_o.x   = !pg_nx_i && (user_mode_i || !xprot_i || !pg_user_i);
  assign user_flt_o = user_mode_i && !pg_user_i;
endmodule

// File: rtl/acc_pkey_filter.sv
module acc_pkey_filter
  import acc_chk_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int NKEY = 1 << KEY_W,
  localparam int KREG_W = 2 * NKEY
) (
  input  logic              lma_i,
  input  logic              pg_user_i,
  input  logic              user_mode_i,
  input  logic              wp_i,
  input  logic [KEY_W-1:0]  pkey_i,
  input  logic              ukey_en_i,
  input  logic [KREG_W-1:0] ukey_i,
  input  logic              skey_en_i,
  input  logic [KREG_W-1:0] skey_i,
  output rwx_t              allow_o
);
  logic [KREG_W-1:0] sel_reg;
  logic [NKEY-1:0]   ad_v, wd_v;
  logic              ad, wd;

  always_comb begin
    sel_reg = '0;
    if (lma_i) begin
      if (pg_user_i && ukey_en_i)       sel_reg = ukey_i;
      else if (!pg_user_i && skey_en_i) sel_reg = skey_i;
    end
  end

  for (genvar k = 0; k < NKEY; k++) begin : g_key
    assign ad_v[k] = sel_reg[2*k];
    assign wd_v[k] = sel_reg[2*k+1];
  end

  assign ad = ad_v[pkey_i];
  assign wd = wd_v[pkey_i];

  assign allow_o.r = !ad;
  assign allow_o.w = !ad && !(wd && (user_mode_i || wp_i));
  assign allow_o.x = 1'b1;
endmodule

// File: rtl/acc_fault_encode.sv
module acc_fault_encode
  import acc_chk_pkg::*;
(
  input  logic [1:0]       acc_type_i,
  input  logic             user_mode_i,
  input  rwx_t             base_i,
  input  rwx_t             pk_i,
  input  logic             user_flt_i,
  input  logic             rsvd_i,
  input  logic             nxe_i,
  input  logic             pae_i,
  input  logic             xprot_i,
  input  logic             pg_dirty_i,
  output logic             fault_o,
  output logic [ERR_W-1:0] err_o,
  output rwx_t             grant_o,
  output logic             dirty_upd_o
);
  rwx_t fin;
  logic is_wr, is_fx, fin_req, pk_req, pk_flt;

  assign fin.r = base_i.r & pk_i.r;
  assign fin.w = base_i.w & pk_i.w;
  assign fin.x = base_i.x & pk_i.x;

  assign is_wr = (acc_type_i == ACC_WR);
  assign is_fx = (acc_type_i == ACC_FX);

  always_comb begin
    unique case (acc_type_i)
      ACC_WR:  begin fin_req = fin.w; pk_req = pk_i.w; end
      ACC_FX:  begin fin_req = fin.x; pk_req = pk_i.x; end
      default: begin fin_req = fin.r; pk_req = pk_i.r; end
    endcase
  end

  // priority: reserved bits, user bit, key rights, plain rights
  assign pk_flt  = !rsvd_i && !user_flt_i && !pk_req;
  assign fault_o = rsvd_i || user_flt_i || !fin_req;

  always_comb begin
    err_o = '0;
    if (fault_o) begin
      err_o[EB_P]   = 1'b1;
      err_o[EB_W]   = is_wr;
      err_o[EB_U]   = user_mode_i;
      err_o[EB_RSV] = rsvd_i;
      err_o[EB_ID]  = is_fx && ((nxe_i && pae_i) || xprot_i);
      err_o[EB_PK]  = pk_flt;
    end
  end

  assign grant_o.r   = !fault_o && fin.r;
  assign grant_o.w   = !fault_o && fin.w && (pg_dirty_i || is_wr);
  assign grant_o.x   = !fault_o && fin.x;
  assign dirty_upd_o = !fault_o && is_wr && !pg_dirty_i;
endmodule

// File: rtl/acc_rights_chk.sv
module acc_rights_chk
  import acc_chk_pkg::*;
#(
  parameter int KEY_W = 4,
  localparam int KREG_W = 2 * (1 << KEY_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        acc_type_i,
  input  logic              user_mode_i,
  input  logic              pg_user_i,
  input  logic              pg_write_i,
  input  logic              pg_nx_i,
  input  logic              pg_dirty_i,
  input  logic [KEY_W-1:0]  pkey_i,
  input  logic              rsvd_i,
  input  logic              wp_i,
  input  logic              xprot_i,
  input  logic              sna_i,
  input  logic              nxe_i,
  input  logic              pae_i,
  input  logic              lma_i,
  input  logic              ukey_en_i,
  input  logic [KREG_W-1:0] ukey_i,
  input  logic              skey_en_i,
  input  logic [KREG_W-1:0] skey_i,
  output logic              valid_o,
  output logic              grant_r_o,
  output logic              grant_w_o,
  output logic              grant_x_o,
  output logic              fault_o,
  output logic [ERR_W-1:0]  err_code_o,
  output logic              dirty_upd_o
);
  rwx_t             base, pk_allow, grant_d;
  logic             user_flt, fault_d, dupd_d;
  logic [ERR_W-1:0] err_d;

  acc_rights_base u_base (
    .user_mode_i (user_mode_i),
    .pg_user_i   (pg_user_i),
    .pg_write_i  (pg_write_i),
    .pg_nx_i     (pg_nx_i),
    .wp_i        (wp_i),
    .xprot_i     (xprot_i),
    .sna_i       (sna_i),
    .base_o      (base),
    .user_flt_o  (user_flt)
  );

  acc_pkey_filter #(.KEY_W(KEY_W)) u_pkey (
    .lma_i       (lma_i),
    .pg_user_i   (pg_user_i),
    .user_mode_i (user_mode_i),
    .wp_i        (wp_i),
    .pkey_i      (pkey_i),
    .ukey_en_i   (ukey_en_i),
    .ukey_i      (ukey_i),
    .skey_en_i   (skey_en_i),
    .skey_i      (skey_i),
    .allow_o     (pk_allow)
  );

  acc_fault_encode u_enc (
    .acc_type_i  (acc_type_i),
    .user_mode_i (user_mode_i),
    .base_i      (base),
    .pk_i        (pk_allow),
    .user_flt_i  (user_flt),
    .rsvd_i      (rsvd_i),
    .nxe_i       (nxe_i),
    .pae_i       (pae_i),
    .xprot_i     (xprot_i),
    .pg_dirty_i  (pg_dirty_i),
    .fault_o     (fault_d),
    .err_o       (err_d),
    .grant_o     (grant_d),
    .dirty_upd_o (dupd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      grant_r_o   <= 1'b0;
      grant_w_o   <= 1'b0;
      grant_x_o   <= 1'b0;
      fault_o     <= 1'b0;
      err_code_o  <= '0;
      dirty_upd_o <= 1'b0;
    end else begin
      valid_o     <= valid_i;
      grant_r_o   <= grant_d.r;
      grant_w_o   <= grant_d.w;
      grant_x_o   <= grant_d.x;
      fault_o     <= fault_d;
      err_code_o  <= err_d;
      dirty_upd_o <= dupd_d;
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2
  user_bit_flt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_mode_i && !pg_user_i) |=> (fault_o && err_code_o[EB_P]));

  // R6
  key_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lma_i |-> (pk_allow.r && pk_allow.w));

  // R8
  pk_has_p_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_code_o[EB_PK] |-> (fault_o && err_code_o[EB_P]));

  // R9
  rsvd_no_pk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_code_o[EB_RSV] |-> (!err_code_o[EB_PK] && fault_o));

  // R9
  clean_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (err_code_o == '0));

  // R11
  dirty_needs_w_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_upd_o |-> grant_w_o);

  // R12
  fault_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !(grant_r_o || grant_w_o || grant_x_o || dirty_upd_o));
endmodule

// File: tb/sim_acc_rights_chk.sv
module sim_acc_rights_chk;
  localparam int KEY_W  = 4;
  localparam int KREG_W = 2 * (1 << KEY_W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              valid, umode, ubit, wbit, nxb, dirty, rsvd;
  logic              wp, xprot, sna, nxe, pae, lma, uen, sen;
  logic [1:0]        acc;
  logic [KEY_W-1:0]  pkey;
  logic [KREG_W-1:0] ukey, skey;

  logic       valid_o, gr, gw, gx, flt, dupd;
  logic [5:0] err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  acc_rights_chk #(.KEY_W(KEY_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .acc_type_i(acc),
    .user_mode_i(umode), .pg_user_i(ubit), .pg_write_i(wbit), .pg_nx_i(nxb),
    .pg_dirty_i(dirty), .pkey_i(pkey), .rsvd_i(rsvd), .wp_i(wp),
    .xprot_i(xprot), .sna_i(sna), .nxe_i(nxe), .pae_i(pae), .lma_i(lma),
    .ukey_en_i(uen), .ukey_i(ukey), .skey_en_i(sen), .skey_i(skey),
    .valid_o(valid_o), .grant_r_o(gr), .grant_w_o(gw), .grant_x_o(gx),
    .fault_o(flt), .err_code_o(err), .dirty_upd_o(dupd)
  );

  // reference: {r, w, x, fault, err[5:0], dirty_upd}
  function automatic logic [10:0] ref_out();
    logic r, w, x, pr, pw, ad, wd, need, pneed, uflt, pkf, f, is_wr, is_fx;
    logic [KREG_W-1:0] kr;
    logic [5:0] e;
    is_wr = (acc == 2'b01);
    is_fx = (acc == 2'b10);
    r = !(sna && !umode && ubit);                   // R4
    w = r && (wbit || (!umode && !wp));             // R3
    x = !nxb && (umode || !xprot || !ubit);         // R5
    kr = '0;                                        // R6
    if (lma) begin
      if (ubit && uen) kr = ukey;
      else if (!ubit && sen) kr = skey;
    end
    ad = kr[2*pkey];                                // R7
    wd = kr[2*pkey+1];
    pr = !ad;
    pw = !ad && !(wd && (umode || wp));
    need  = is_wr ? (w && pw) : (is_fx ? x : (r && pr));
    pneed = is_wr ? pw : (is_fx ? 1'b1 : pr);
    uflt  = umode && !ubit;                         // R2
    pkf   = !rsvd && !uflt && !pneed;               // R8
    f     = rsvd || uflt || !need;
    e = '0;
    if (f) begin                                    // R9 R10
      e[0] = 1'b1; e[1] = is_wr; e[2] = umode; e[3] = rsvd;
      e[4] = is_fx && ((nxe && pae) || xprot); e[5] = pkf;
    end
    return {!f && r && pr, !f && w && pw && (dirty || is_wr), !f && x,
            f, e, !f && is_wr && !dirty};            // R11 R12
  endfunction

  task automatic ck(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    valid = 1'b1; acc = 2'b00; umode = 1'b0; ubit = 1'b1; wbit = 1'b1;
    nxb = 1'b0; dirty = 1'b1; rsvd = 1'b0; pkey = '0; wp = 1'b0;
    xprot = 1'b0; sna = 1'b0; nxe = 1'b0; pae = 1'b0; lma = 1'b0;
    uen = 1'b0; sen = 1'b0; ukey = '0; skey = '0;
  endtask

  // inputs set at a negedge; result checked at the following negedge
  task automatic step(string tag);
    logic [10:0] ex;
    logic        vex;
    ex  = ref_out();
    vex = valid;
    @(posedge clk);
    @(negedge clk);
    ck({tag, " R1 valid"}, 32'(valid_o), 32'(vex));
    ck({tag, " R4 grant_r"}, 32'(gr), 32'(ex[10]));
    ck({tag, " R3 grant_w"}, 32'(gw), 32'(ex[9]));
    ck({tag, " R5 grant_x"}, 32'(gx), 32'(ex[8]));
    ck({tag, " R2 fault"}, 32'(flt), 32'(ex[7]));
    ck({tag, " R9 err"}, 32'(err), 32'(ex[6:1]));
    ck({tag, " R11 dirty"}, 32'(dupd), 32'(ex[0]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    clr();
    umode = 1'b1; ubit = 1'b0;          // would fault if not in reset
    repeat (3) @(negedge clk);
    // R1 reset state
    ck("R1 reset", {25'd0, valid_o, gr, gw, gx, flt, dupd, 1'b0}, 32'd0);
    ck("R1 reset err", 32'(err), 32'd0);
    rst_n = 1'b1;

    // R2 user access to supervisor page
    clr(); umode = 1'b1; ubit = 1'b0; step("R2");
    ck("R2 err", 32'(err), 32'h05);

    // R1 output does not move before the edge
    clr(); #1;
    ck("R1 hold fault", 32'(flt), 32'd1);
    step("R1");

    // R3 supervisor write to read-only page
    clr(); acc = 2'b01; wbit = 1'b0; step("R3 wp0");
    ck("R3 wp0 grant_w", 32'(gw), 32'd1);
    clr(); acc = 2'b01; wbit = 1'b0; wp = 1'b1; step("R3 wp1");
    ck("R3 wp1 err", 32'(err), 32'h03);
    clr(); acc = 2'b01; wbit = 1'b0; umode = 1'b1; step("R3 user");
    ck("R3 user err", 32'(err), 32'h07);

    // R4 supervisor no-access to user page
    clr(); sna = 1'b1; step("R4");
    ck("R4 err", 32'(err), 32'h01);
    clr(); sna = 1'b1; acc = 2'b10; step("R4 fetch");
    ck("R4 fetch grant_x", 32'(gx), 32'd1);

    // R5 R10 execute protection
    clr(); acc = 2'b10; xprot = 1'b1; step("R5");
    ck("R10 xprot err", 32'(err), 32'h11);
    clr(); acc = 2'b10; nxb = 1'b1; umode = 1'b1; nxe = 1'b1; pae = 1'b1;
    step("R10 nx");
    ck("R10 nx err", 32'(err), 32'h15);
    clr(); acc = 2'b10; nxb = 1'b1; umode = 1'b1; pae = 1'b1; step("R10 no nxe");
    ck("R10 no nxe err", 32'(err), 32'h05);

    // R6 R7 R8 keys
    clr(); umode = 1'b1; lma = 1'b1; uen = 1'b1; pkey = 4'd5;
    ukey = 32'h1 << 10; step("R7 ad");
    ck("R8 pk err", 32'(err), 32'h25);
    clr(); umode = 1'b1; uen = 1'b1; pkey = 4'd5; ukey = 32'h1 << 10;
    step("R6 no lma");
    ck("R6 no lma fault", 32'(flt), 32'd0);
    clr(); umode = 1'b1; lma = 1'b1; pkey = 4'd5; ukey = 32'h1 << 10;
    step("R6 uen0");
    ck("R6 uen0 fault", 32'(flt), 32'd0);
    clr(); ubit = 1'b0; acc = 2'b01; lma = 1'b1; sen = 1'b1; pkey = 4'd3;
    skey = 32'h1 << 7; step("R7 wd wp0");
    ck("R7 wd wp0 grant_w", 32'(gw), 32'd1);
    clr(); ubit = 1'b0; acc = 2'b01; lma = 1'b1; sen = 1'b1; pkey = 4'd3;
    skey = 32'h1 << 7; wp = 1'b1; step("R7 wd wp1");
    ck("R8 wd err", 32'(err), 32'h23);
    clr(); umode = 1'b1; acc = 2'b01; wbit = 1'b0; lma = 1'b1; uen = 1'b1;
    pkey = 4'd15; ukey = 32'h1 << 31; step("R8 both");
    ck("R8 both err", 32'(err), 32'h27);
    clr(); acc = 2'b10; lma = 1'b1; uen = 1'b1; ukey = '1; step("R7 fetch");
    ck("R7 fetch fault", 32'(flt), 32'd0);

    // R9 reserved-bit fault beats keys
    clr(); rsvd = 1'b1; lma = 1'b1; uen = 1'b1; ukey = '1; step("R9 rsvd");
    ck("R9 rsvd err", 32'(err), 32'h09);

    // R11 dirty handling
    clr(); acc = 2'b01; dirty = 1'b0; step("R11 wr");
    ck("R11 dupd", 32'(dupd), 32'd1);
    clr(); dirty = 1'b0; step("R11 rd");
    ck("R11 clean grant_w", 32'(gw), 32'd0);

    // R12 fault blocks grants
    clr(); acc = 2'b01; dirty = 1'b0; wbit = 1'b0; wp = 1'b1; step("R12");
    ck("R12 grants", {29'd0, gr, gx, dupd}, 32'd0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      valid = ($urandom % 8) != 0;
      acc   = 2'($urandom % 4);
      {umode, ubit, wbit, nxb, dirty} = 5'($urandom);
      rsvd  = ($urandom % 8) == 0;
      {wp, xprot, sna, nxe, pae, lma, uen, sen} = 8'($urandom);
      pkey  = 4'($urandom);
      ukey  = $urandom & $urandom;
      skey  = $urandom & $urandom;
      step("RND");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule